// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel Transfer Engine

This block moves a block of data items from one address range to another for one channel. When the channel is enabled and a request arrives, it reads a 16-byte descriptor from a control-structure area in memory. The descriptor holds the source end pointer, the destination end pointer and a control word. The engine decodes the control word and copies items one at a time through a single synchronous memory port. It reads each item from the source and then writes it to the destination.

The control word sets the item size, the address step on each side and the item count, which is stored as the count minus one. It also sets how many items move before the engine gives up the bus and re-arbitrates, and the cycle mode. There are four cycle modes:
- **Stop:** the descriptor is invalid.
- **Basic:** each burst needs the request to still be present.
- **Auto:** one request runs the whole cycle.
- **Ping-pong:** the engine alternates between the primary and the alternate descriptor.

After every burst the engine writes the updated control word back into the descriptor. When a cycle finishes it pulses `done`.

Top module: `dma_desc_engine`

## Requirements
- R1: The primary descriptor sits at `ctl_base` and the alternate at `ctl_base + 16`. Within a descriptor, byte offset 0 holds the source end pointer, offset 4 the destination end pointer and offset 8 the control word. Offset 12 is never accessed.
- R2: Control word fields by bit position:
  - [2:0] cycle code
  - [3] burst hint (ignored)
  - [13:4] remaining count minus one
  - [17:14] arbitration power
  - [20:18] source protection (ignored)
  - [23:21] destination protection (ignored)
  - [25:24] source size
  - [27:26] source step
  - [29:28] destination size
  - [31:30] destination step
- R3: Item i of a cycle whose count field is M uses address `end − (M − i) × step`. Step code 00 means 1 byte, 01 means 2, 10 means 4, and 11 means 0, so every item uses the end pointer.
- R4: Size code 00 is byte, 01 halfword and 10 word (code 11 is treated as word) and is driven on `mem_size`. Data travels right-justified, byte 0 in bits [7:0]. A write stores only the low bytes for the destination size.
- R5: If the fetched cycle code is 000 (stop) or 100 to 111, the engine gives a one-cycle `err` pulse. It writes neither data nor the descriptor.
- R6: In basic mode, a new burst starts only while `xfer_req` is high. When a burst ends without the request, the engine stops and later resumes at the next item.
- R7: In auto mode, a single-cycle request pulse completes the whole cycle, however many bursts it takes.
- R8: In ping-pong mode, the primary descriptor is used first. Each completed cycle switches the next request to the other descriptor. Dropping `ch_en` while idle selects the primary again.
- R9: A burst is 2^R items for R codes 0000 to 1001, and 1024 items for codes 1010 to 1111. The descriptor is fetched again for every burst. After a burst that leaves items unfinished, the engine writes the control word back with the remaining count minus one and the cycle code unchanged.
- R10: At the end of a cycle, the control word is written back with count field 0. The cycle code becomes 000, except in ping-pong mode where it is kept. `done` is high for exactly one cycle, the cycle after that write is accepted.
- R11: Once `mem_req` is raised, address, write enable, size and write data hold steady until `mem_ready`. The engine stays correct under any pattern of wait cycles.
- R12: During and after reset, `mem_req`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable; low while idle returns selection to the primary descriptor |
| xfer_req | input | 1 | Transfer request, sampled while idle |
| ctl_base | input | ADDR_W | Byte address of the primary descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Access size: 00 byte, 01 halfword, 10 word |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Completes the current access |
| busy | output | 1 | Engine is not idle |
| done | output | 1 | One-cycle pulse at cycle completion |
| err | output | 1 | One-cycle pulse on an invalid descriptor |

## Verification
A table of vectors runs auto and basic cycles with byte, halfword and word items. Counts range from one item to 1024, and burst powers are chosen so that a cycle takes one burst, several bursts, or a clamped 1024-item burst. Checking the descriptor-fetch count separates a wrong burst length from a wrong item address. A fixed source address and a fixed destination address (only the last item survives) test the no-step code on each side. Odd vectors add wait cycles on the memory port. Directed runs then cover:
- a stop-coded and a scatter-coded descriptor, which must give an error and no writes;
- a basic cycle whose request is withdrawn after the first burst, so that the partial copy and the written-back count can be seen;
- a ping-pong sequence that shows which descriptor each request used before and after the channel is disabled.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 10;
  localparam int MAX_POW = 10;
  localparam int BURST_W = MAX_POW + 1;

  localparam logic [2:0] CC_STOP  = 3'b000;
  localparam logic [2:0] CC_BASIC = 3'b001;
  localparam logic [2:0] CC_AUTO  = 3'b010;
  localparam logic [2:0] CC_PPONG = 3'b011;

  localparam logic [1:0] STEP_NONE = 2'b11;
  localparam logic [1:0] SZ_WORD   = 2'b10;

  typedef struct packed {
    logic [1:0]       d_step;
    logic [1:0]       d_size;
    logic [1:0]       s_step;
    logic [1:0]       s_size;
    logic [2:0]       d_prot;
    logic [2:0]       s_prot;
    logic [3:0]       arb_pow;
    logic [CNT_W-1:0] cnt_m1;
    logic             burst_hint;
    logic [2:0]       cyc;
  } ctl_word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FSRC,
    ST_FDST,
    ST_FCTL,
    ST_READ,
    ST_WRITE,
    ST_WBACK
  } eng_state_e;

  function automatic logic [BURST_W-1:0] burst_len(input logic [3:0] pow);
    if (pow >= 4'(MAX_POW)) return BURST_W'(1) << MAX_POW;
    return BURST_W'(1) << pow;
  endfunction

  function automatic logic [1:0] bus_size(input logic [1:0] code);
    return (code == 2'b11) ? SZ_WORD : code;
  endfunction

  function automatic logic cyc_runs(input logic [2:0] code);
    return (code == CC_BASIC) || (code == CC_AUTO) || (code == CC_PPONG);
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] end_ptr,
  input  logic [CNT_W-1:0]  left,
  input  logic [1:0]        step,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] back_off;

  always_comb begin
    back_off = '0;
    if (step != STEP_NONE) begin
      back_off = ADDR_W'(left) << step;
    end
    addr = end_ptr - back_off;
  end

endmodule

// File: rtl/dma_arb_ctr.sv
module dma_arb_ctr
  import dma_eng_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BURST_W-1:0] len,
  input  logic               step,
  output logic               last
);

  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = len;
    end else if (step && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == BURST_W'(1));

endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_en,
  input  logic              xfer_req,
  input  logic [ADDR_W-1:0] ctl_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam logic [ADDR_W-1:0] OFS_DST = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_ALT = ADDR_W'(DESC_BYTES);
  localparam int                SIDES   = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  eng_state_e        state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  ctl_word_t         ctl_q, ctl_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              alt_q, alt_d;
  logic              apend_q, apend_d;
  logic              last_q, last_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic              xfer;
  logic              burst_last;
  logic              burst_load;
  logic              burst_step;
  ctl_word_t         ctl_in;
  logic [ADDR_W-1:0] desc_base;

  logic [ADDR_W-1:0] side_end  [SIDES];
  logic [1:0]        side_step [SIDES];
  logic [ADDR_W-1:0] side_addr [SIDES];

  assign ctl_in    = ctl_word_t'(mem_rdata);
  assign xfer      = mem_req && mem_ready;
  assign desc_base = ctl_base + (alt_q ? OFS_ALT : '0);

  assign side_end[0]  = src_q;
  assign side_end[1]  = dst_q;
  assign side_step[0] = ctl_q.s_step;
  assign side_step[1] = ctl_q.d_step;

  // one address generator per side: source then destination
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dma_addr_gen #(
      .ADDR_W (ADDR_W)
    ) i_addr_gen (
      .end_ptr (side_end[s]),
      .left    (ctl_q.cnt_m1),
      .step    (side_step[s]),
      .addr    (side_addr[s])
    );
  end

  assign burst_load = (state_q == ST_FCTL) && xfer && cyc_runs(ctl_in.cyc);
  assign burst_step = (state_q == ST_WRITE) && xfer;

  dma_arb_ctr i_arb_ctr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (burst_load),
    .len   (burst_len(ctl_in.arb_pow)),
    .step  (burst_step),
    .last  (burst_last)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    ctl_d   = ctl_q;
    data_d  = data_q;
    alt_d   = alt_q;
    apend_d = apend_q;
    last_d  = last_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!ch_en) begin
          alt_d   = 1'b0;
          apend_d = 1'b0;
        end else if (xfer_req || apend_q) begin
          state_d = ST_FSRC;
        end
      end
      ST_FSRC: begin
        if (xfer) begin
          src_d   = mem_rdata[ADDR_W-1:0];
          state_d = ST_FDST;
        end
      end
      ST_FDST: begin
        if (xfer) begin
          dst_d   = mem_rdata[ADDR_W-1:0];
          state_d = ST_FCTL;
        end
      end
      ST_FCTL: begin
        if (xfer) begin
          ctl_d = ctl_in;
          if (cyc_runs(ctl_in.cyc)) begin
            state_d = ST_READ;
          end else begin
            err_d   = 1'b1;
            apend_d = 1'b0;
            state_d = ST_IDLE;
          end
        end
      end
      ST_READ: begin
        if (xfer) begin
          data_d  = mem_rdata;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (xfer) begin
          if (ctl_q.cnt_m1 == '0) begin
            last_d  = 1'b1;
            state_d = ST_WBACK;
            if (ctl_q.cyc != CC_PPONG) begin
              ctl_d.cyc = CC_STOP;
            end
          end else begin
            ctl_d.cnt_m1 = ctl_q.cnt_m1 - 1'b1;
            last_d       = 1'b0;
            state_d      = burst_last ? ST_WBACK : ST_READ;
          end
        end
      end
      ST_WBACK: begin
        if (xfer) begin
          state_d = ST_IDLE;
          if (last_q) begin
            done_d  = 1'b1;
            apend_d = 1'b0;
            if (ctl_q.cyc == CC_PPONG) begin
              alt_d = ~alt_q;
            end
          end else begin
            apend_d = (ctl_q.cyc == CC_AUTO);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      ctl_q   <= '0;
      data_q  <= '0;
      alt_q   <= 1'b0;
      apend_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      ctl_q   <= ctl_d;
      data_q  <= data_d;
      alt_q   <= alt_d;
      apend_q <= apend_d;
      last_q  <= last_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // memory port
  always_comb begin
    mem_req   = (state_q != ST_IDLE);
    mem_we    = (state_q == ST_WRITE) || (state_q == ST_WBACK);
    mem_size  = SZ_WORD;
    mem_wdata = data_q;
    mem_addr  = desc_base;
    unique case (state_q)
      ST_FDST:  mem_addr = desc_base + OFS_DST;
      ST_FCTL:  mem_addr = desc_base + OFS_CTL;
      ST_READ: begin
        mem_addr = side_addr[0];
        mem_size = bus_size(ctl_q.s_size);
      end
      ST_WRITE: begin
        mem_addr = side_addr[1];
        mem_size = bus_size(ctl_q.d_size);
      end
      ST_WBACK: begin
        mem_addr  = desc_base + OFS_CTL;
        mem_wdata = WORD_W'(ctl_q);
      end
      default:  mem_addr = desc_base;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/dma_desc_engine_chk.sv
module dma_desc_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_size,
  input logic [31:0]       mem_wdata,
  input logic              busy,
  input logic              done,
  input logic              err
);

  // R11: a pending access keeps its attributes until accepted
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_size) && $stable(mem_wdata)));

  // R10: done lasts one cycle and follows an accepted write
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_we && mem_ready));

  // R5: err lasts one cycle and follows an accepted read
  a_r5_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  a_r5_err_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(mem_req && !mem_we && mem_ready));

  // R4: only legal sizes reach the port
  a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size != 2'b11));

  // R12: no memory traffic while idle
  a_r12_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r5_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

endmodule

bind dma_desc_engine dma_desc_engine_chk #(
  .ADDR_W (ADDR_W)
) i_dma_desc_engine_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_wdata (mem_wdata),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/test_dma_desc_engine.sv
module test_dma_desc_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int MEM_BYTES  = 4096;
  localparam int NVEC       = 9;

  // {cycle[3], s_size[2], s_step[2], d_size[2], d_step[2], pow[4], cnt_m1[10], bursts[8]}
  localparam logic [32:0] VECS [NVEC] = '{
    {3'd2, 2'd0, 2'd0, 2'd0, 2'd0, 4'd2,  10'd15,   8'd4},
    {3'd2, 2'd1, 2'd1, 2'd1, 2'd1, 4'd3,  10'd7,    8'd1},
    {3'd2, 2'd2, 2'd2, 2'd2, 2'd2, 4'd1,  10'd4,    8'd3},
    {3'd1, 2'd2, 2'd2, 2'd2, 2'd2, 4'd2,  10'd9,    8'd3},
    {3'd2, 2'd0, 2'd0, 2'd0, 2'd3, 4'd0,  10'd5,    8'd6},
    {3'd2, 2'd2, 2'd3, 2'd2, 2'd2, 4'd10, 10'd3,    8'd1},
    {3'd2, 2'd1, 2'd1, 2'd1, 2'd1, 4'd0,  10'd0,    8'd1},
    {3'd2, 2'd0, 2'd0, 2'd0, 2'd0, 4'd15, 10'd39,   8'd1},
    {3'd2, 2'd0, 2'd0, 2'd0, 2'd0, 4'd9,  10'd1023, 8'd2}
  };

  logic          clk;
  logic          rst_n;
  logic          ch_en;
  logic          xfer_req;
  logic [AW-1:0] ctl_base;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;
  logic          mem_ready;
  logic          busy;
  logic          done;
  logic          err;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_cnt  = 0;
  int fetch_cnt = 0;

  logic       stall_en;
  logic       stall_ph;
  logic [7:0] mem  [MEM_BYTES];
  logic [7:0] expm [MEM_BYTES];
  logic [11:0] ma;

  dma_desc_engine #(
    .ADDR_W     (AW),
    .DESC_BYTES (16)
  ) i_dma_desc_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_en),
    .xfer_req  (xfer_req),
    .ctl_base  (ctl_base),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // memory model: zero-wait unless stalls are enabled
  assign ma        = mem_addr[11:0];
  assign mem_rdata = {mem[ma + 12'd3], mem[ma + 12'd2], mem[ma + 12'd1], mem[ma]};
  assign mem_ready = mem_req && !(stall_en && stall_ph);

  always @(posedge clk) begin
    stall_ph <= ~stall_ph;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        wr_cnt  <= wr_cnt + 1;
        mem[ma] <= mem_wdata[7:0];
        if (mem_size != 2'b00) mem[ma + 12'd1] <= mem_wdata[15:8];
        if (mem_size == 2'b10) begin
          mem[ma + 12'd2] <= mem_wdata[23:16];
          mem[ma + 12'd3] <= mem_wdata[31:24];
        end
      end else if (ma < 12'd32 && ma[3:0] == 4'd8) begin
        fetch_cnt <= fetch_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) mem[a + b] = w[8*b +: 8];
  endtask

  function automatic logic [31:0] get_word(input int a);
    return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
  endfunction

  function automatic int step_of(input logic [1:0] code);
    return (code == 2'b11) ? 0 : (1 << code);
  endfunction

  function automatic int bytes_of(input logic [1:0] code);
    return (code == 2'b00) ? 1 : (code == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mk_ctl(input logic [2:0] cyc, input logic [1:0] ss,
      input logic [1:0] si, input logic [1:0] ds, input logic [1:0] di,
      input logic [3:0] pw, input logic [9:0] n);
    return {di, ds, si, ss, 3'b000, 3'b000, pw, n, 1'b0, cyc};
  endfunction

  task automatic prep_mem(input int seed);
    for (int a = 0; a < MEM_BYTES; a++) begin
      if (a >= 12'h100 && a < 12'h500) mem[a] = 8'((a * 7 + seed * 5 + 1) & 8'hff);
      else if (a >= 12'h800 && a < 12'he00) mem[a] = 8'h00;
    end
  endtask

  task automatic snap_exp();
    for (int a = 0; a < MEM_BYTES; a++) expm[a] = mem[a];
  endtask

  task automatic model(input int se, input int de, input int n, input logic [1:0] si,
                       input logic [1:0] ds, input logic [1:0] di, input logic [1:0] ss);
    int sstep;
    int dstep;
    sstep = step_of(si);
    dstep = step_of(di);
    for (int i = 0; i <= n; i++) begin
      int sa;
      int da;
      logic [31:0] val;
      sa  = se - (n - i) * sstep;
      da  = de - (n - i) * dstep;
      val = {expm[sa + 3], expm[sa + 2], expm[sa + 1], expm[sa]};
      for (int b = 0; b < bytes_of(ds); b++) expm[da + b] = val[8*b +: 8];
    end
    if (ss == 2'b11) sstep = 0;
  endtask

  function automatic int mismatches(input int lo, input int hi);
    int m;
    m = 0;
    for (int a = lo; a < hi; a++) if (mem[a] !== expm[a]) m++;
    return m;
  endfunction

  task automatic wait_end(output bit got_done, output bit got_err);
    got_done = 1'b0;
    got_err  = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done) got_done = 1'b1;
      if (err)  got_err  = 1'b1;
      if (got_done || got_err) break;
    end
    xfer_req = 1'b0;
    if (!got_done && !got_err) chk(1'b0, "watchdog: no done/err", 32'd0, 32'd1);
  endtask

  task automatic pulse_req();
    @(negedge clk);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
  endtask

  task automatic run_vec(input logic [32:0] v, input int k);
    logic [2:0] cyc;
    logic [1:0] ss, si, ds, di;
    logic [3:0] pw;
    logic [9:0] n;
    logic [7:0] nb;
    int se, de, f0;
    bit gd, ge;
    {cyc, ss, si, ds, di, pw, n, nb} = v;
    se = 12'h100 + int'(n) * step_of(si);
    de = 12'h800 + int'(n) * step_of(di);
    prep_mem(k);
    put_word(0, se);
    put_word(4, de);
    put_word(8, mk_ctl(cyc, ss, si, ds, di, pw, n));
    put_word(12, 32'h0);
    snap_exp();
    model(se, de, int'(n), si, ds, di, ss);
    stall_en = k[0];
    f0 = fetch_cnt;
    @(negedge clk);
    xfer_req = 1'b1;
    if (cyc != 3'd1) begin
      @(negedge clk);
      xfer_req = 1'b0;
    end
    wait_end(gd, ge);
    stall_en = 1'b0;
    // R1/R3/R4/R11: data at computed addresses, right-justified, with or without stalls
    chk(mismatches(12'h800, 12'he00) == 0, $sformatf("R1/R3/R4/R11 vec %0d dest data", k),
        mismatches(12'h800, 12'he00), 0);
    // R2/R10: final control word
    chk(get_word(8) == mk_ctl(3'd0, ss, si, ds, di, pw, 10'd0),
        $sformatf("R2/R10 vec %0d ctl writeback", k), get_word(8),
        mk_ctl(3'd0, ss, si, ds, di, pw, 10'd0));
    // R9: one descriptor fetch per burst
    chk(fetch_cnt - f0 == int'(nb), $sformatf("R9 vec %0d burst count", k),
        fetch_cnt - f0, nb);
    // R6 (basic, held) / R7 (auto, single pulse)
    chk(gd && !ge, $sformatf("R6/R7 vec %0d completion", k), {gd, ge}, 2'b10);
  endtask

  task automatic set_desc(input int base, input int se, input int de, input logic [31:0] c);
    put_word(base, se);
    put_word(base + 4, de);
    put_word(base + 8, c);
  endtask

  function automatic int pp_bad(input int s0, input int d0, input int n);
    int m;
    m = 0;
    for (int i = 0; i < n; i++) if (mem[d0 + i] !== mem[s0 + i]) m++;
    return m;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit gd, ge;
    int w0, d_seen;
    rst_n    = 1'b0;
    ch_en    = 1'b1;
    xfer_req = 1'b0;
    ctl_base = '0;
    stall_en = 1'b0;
    stall_ph = 1'b0;
    for (int a = 0; a < MEM_BYTES; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    // R12: quiet during reset
    chk(!mem_req && !busy && !done && !err, "R12 reset state",
        {mem_req, busy, done, err}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !busy && !done && !err, "R12 after reset",
        {mem_req, busy, done, err}, 4'b0000);

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

    // R5: stop-coded descriptor
    prep_mem(20);
    set_desc(0, 12'h103, 12'h803, mk_ctl(3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd2, 10'd3));
    w0 = wr_cnt;
    pulse_req();
    wait_end(gd, ge);
    chk(ge && !gd, "R5 stop gives err", {gd, ge}, 2'b01);
    chk(wr_cnt == w0, "R5 stop makes no writes", wr_cnt - w0, 0);
    chk(get_word(8) == mk_ctl(3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd2, 10'd3),
        "R5 stop ctl unchanged", get_word(8),
        mk_ctl(3'd0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd2, 10'd3));
    // R5: scatter code treated as invalid
    put_word(8, mk_ctl(3'd5, 2'd0, 2'd0, 2'd0, 2'd0, 4'd2, 10'd3));
    w0 = wr_cnt;
    pulse_req();
    wait_end(gd, ge);
    chk(ge && wr_cnt == w0, "R5 code 101 err, no write", wr_cnt - w0, 0);

    // R6/R9: basic, request withdrawn after the first burst
    prep_mem(21);
    set_desc(0, 12'h107, 12'h807, mk_ctl(3'd1, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1, 10'd7));
    d_seen = 0;
    pulse_req();
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (done) d_seen++;
    end
    chk(d_seen == 0 && !busy, "R6 basic stalls without request", {d_seen[0], busy}, 2'b00);
    chk(pp_bad(12'h100, 12'h800, 2) == 0 && mem[12'h802] == 8'h00 && mem[12'h807] == 8'h00,
        "R6 basic partial copy", {mem[12'h802], mem[12'h807]}, 16'h0);
    chk(get_word(8) == mk_ctl(3'd1, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1, 10'd5),
        "R9 mid-cycle count writeback", get_word(8),
        mk_ctl(3'd1, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1, 10'd5));
    @(negedge clk);
    xfer_req = 1'b1;
    wait_end(gd, ge);
    chk(gd && pp_bad(12'h100, 12'h800, 8) == 0, "R6 basic resumes and completes",
        pp_bad(12'h100, 12'h800, 8), 0);

    // R8: ping-pong alternation
    prep_mem(22);
    set_desc(0,  12'h103, 12'h903, mk_ctl(3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 4'd15, 10'd3));
    set_desc(16, 12'h203, 12'ha03, mk_ctl(3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 4'd15, 10'd3));
    pulse_req();
    wait_end(gd, ge);
    chk(gd && pp_bad(12'h100, 12'h900, 4) == 0 && mem[12'ha00] == 8'h00,
        "R8 primary runs first", pp_bad(12'h100, 12'h900, 4), 0);
    chk(get_word(8) == mk_ctl(3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 4'd15, 10'd0),
        "R8/R10 ping-pong keeps cycle code", get_word(8),
        mk_ctl(3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 4'd15, 10'd0));
    pulse_req();
    wait_end(gd, ge);
    chk(gd && pp_bad(12'h200, 12'ha00, 4) == 0, "R8 alternate runs second",
        pp_bad(12'h200, 12'ha00, 4), 0);
    set_desc(0, 12'h101, 12'hb01, mk_ctl(3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 4'd15, 10'd1));
    pulse_req();
    wait_end(gd, ge);
    chk(gd && pp_bad(12'h100, 12'hb00, 2) == 0, "R8 back to primary",
        pp_bad(12'h100, 12'hb00, 2), 0);
    // alternate is now selected; disabling returns to primary
    @(negedge clk);
    ch_en = 1'b0;
    repeat (2) @(negedge clk);
    ch_en = 1'b1;
    set_desc(0, 12'h101, 12'hc01, mk_ctl(3'd3, 2'd0, 2'd0, 2'd0, 2'd0, 4'd15, 10'd1));
    pulse_req();
    wait_end(gd, ge);
    chk(gd && pp_bad(12'h100, 12'hc00, 2) == 0, "R8 disable selects primary",
        pp_bad(12'h100, 12'hc00, 2), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule